// File: doc/BRIEF.md
# Comparator Edge Flag Request Unit

This block sits behind an analog comparator's filter stage and turns changes of the filtered output into service requests. It compares the current output with its value from the previous bus clock cycle. A low-to-high change sets a sticky rising flag, and a high-to-low change sets a sticky falling flag. Each flag stays set until software clears it with a one-cycle clear strobe or, in DMA mode, until the DMA controller acknowledges a transfer.

A flag only raises a request when its own enable is set. Both enabled flags feed one shared request. A DMA-select bit decides where that request goes: to the CPU interrupt line, or to the DMA request line. It never drives both. The flags themselves are recorded whether or not their enables are set, so software can poll them.

Top module: `cmp_edge_req`

## Requirements
- R1: While reset is high, and in the first cycle after it, both flags, the interrupt line and the DMA request line are low.
- R2: If the output is high at a clock edge and was low at the previous edge (both after reset), the rising flag reads one from that edge onward.
- R3: If the output is low at a clock edge and was high at the previous edge (both after reset), the falling flag reads one from that edge onward.
- R4: The first clock edge after reset never sets a flag, whatever level the output has.
- R5: A set flag stays set while no clear applies to it, regardless of further output changes and of the enables.
- R6: A clear strobe clears only its own flag at the next edge. If an edge of the same direction occurs at that same clock edge, the flag is set instead.
- R7: The request is active while (rising enable and rising flag) or (falling enable and falling flag). It stays active until every enabled flag has been cleared.
- R8: With DMA select low, the interrupt line equals the request and the DMA request line is low.
- R9: With DMA select high, the DMA request line equals the request and the interrupt line is low.
- R10: A DMA acknowledge with DMA select high clears both flags at the next edge, unless a set applies. With DMA select low, the acknowledge has no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cout_i | input | 1 | Filtered comparator output |
| rise_en_i | input | 1 | Rising-flag request enable |
| fall_en_i | input | 1 | Falling-flag request enable |
| dma_sel_i | input | 1 | Route the request to the DMA line instead of the interrupt line |
| clr_rise_i | input | 1 | Write-one-to-clear strobe for the rising flag |
| clr_fall_i | input | 1 | Write-one-to-clear strobe for the falling flag |
| dma_ack_i | input | 1 | DMA acknowledge; clears the flags in DMA mode |
| rise_flag_o | output | 1 | Sticky rising flag |
| fall_flag_o | output | 1 | Sticky falling flag |
| irq_o | output | 1 | CPU interrupt request |
| dma_req_o | output | 1 | DMA request |

## Verification
The hardest case to reach from the ports is an output edge that lands in the same clock cycle as a clear strobe or a DMA acknowledge for the same flag. The set must win, and random toggling rarely lines the two up. Directed steps drive the output change and the strobe on the same falling clock edge. They also hold the output high through reset, to show that the first edge after reset is quiet. A seeded random phase then mixes toggles, strobes, acknowledges and enable changes at biased rates, and compares every output with a bench model each cycle.

// File: rtl/cmp_edge_pkg.sv
package cmp_edge_pkg;

    // One bit per edge direction; used for edges, flags, enables and clears.
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_pair_t;

    localparam edge_pair_t EDGE_NONE = '{rise: 1'b0, fall: 1'b0};

    // Request qualifier: a flag counts only when its enable is set.
    function automatic logic pair_request(edge_pair_t flags, edge_pair_t en);
        return (flags.rise & en.rise) | (flags.fall & en.fall);
    endfunction

    // Next flag state: a fresh edge wins over any clear.
    function automatic edge_pair_t pair_next(edge_pair_t cur, edge_pair_t set,
                                             edge_pair_t clr);
        edge_pair_t nxt;
        nxt.rise = set.rise | (cur.rise & ~clr.rise);
        nxt.fall = set.fall | (cur.fall & ~clr.fall);
        return nxt;
    endfunction

endpackage

// File: rtl/cmp_edge_detect.sv
module cmp_edge_detect
    import cmp_edge_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cout_i,
    output edge_pair_t edges_o
);

    logic prev_q;
    logic armed_q;

    // armed_q keeps the first cycle after reset from reporting an edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            prev_q  <= cout_i;
            armed_q <= 1'b1;
        end
    end

    always_comb begin
        edges_o.rise = armed_q &  cout_i & ~prev_q;
        edges_o.fall = armed_q & ~cout_i &  prev_q;
    end

endmodule

// File: rtl/cmp_edge_flags.sv
module cmp_edge_flags
    import cmp_edge_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  edge_pair_t edges_i,
    input  edge_pair_t clr_i,
    input  logic       ack_clr_i,
    output edge_pair_t flags_o
);

    edge_pair_t flags_q;
    edge_pair_t clr_eff;

    always_comb begin
        clr_eff.rise = clr_i.rise | ack_clr_i;
        clr_eff.fall = clr_i.fall | ack_clr_i;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= EDGE_NONE;
        else     flags_q <= pair_next(flags_q, edges_i, clr_eff);
    end

    assign flags_o = flags_q;

    AST_RISE_SETS: assert property (@(posedge clk) disable iff (rst)
        edges_i.rise |=> flags_q.rise); // R2
    AST_FALL_SETS: assert property (@(posedge clk) disable iff (rst)
        edges_i.fall |=> flags_q.fall); // R3
    AST_RISE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flags_q.rise && !clr_eff.rise) |=> flags_q.rise); // R5
    AST_FALL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flags_q.fall && !clr_eff.fall) |=> flags_q.fall); // R5
    AST_RISE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (clr_eff.rise && !edges_i.rise) |=> !flags_q.rise); // R6
    AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (clr_eff.fall && !edges_i.fall) |=> !flags_q.fall); // R6

endmodule

// File: rtl/cmp_req_route.sv
module cmp_req_route
    import cmp_edge_pkg::*;
(
    input  edge_pair_t flags_i,
    input  edge_pair_t en_i,
    input  logic       dma_sel_i,
    output logic       irq_o,
    output logic       dma_req_o
);

    logic req;

    always_comb begin
        req       = pair_request(flags_i, en_i);
        irq_o     = req & ~dma_sel_i;
        dma_req_o = req &  dma_sel_i;
    end

endmodule

// File: rtl/cmp_edge_req.sv
module cmp_edge_req
    import cmp_edge_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cout_i,
    input  logic rise_en_i,
    input  logic fall_en_i,
    input  logic dma_sel_i,
    input  logic clr_rise_i,
    input  logic clr_fall_i,
    input  logic dma_ack_i,
    output logic rise_flag_o,
    output logic fall_flag_o,
    output logic irq_o,
    output logic dma_req_o
);

    edge_pair_t edges;
    edge_pair_t flags;
    edge_pair_t clr;
    edge_pair_t en;
    logic       ack_clr;

    assign clr     = '{rise: clr_rise_i, fall: clr_fall_i};
    assign en      = '{rise: rise_en_i,  fall: fall_en_i};
    assign ack_clr = dma_ack_i & dma_sel_i;

    cmp_edge_detect i_detect (
        .clk     (clk),
        .rst     (rst),
        .cout_i  (cout_i),
        .edges_o (edges)
    );

    cmp_edge_flags i_flags (
        .clk       (clk),
        .rst       (rst),
        .edges_i   (edges),
        .clr_i     (clr),
        .ack_clr_i (ack_clr),
        .flags_o   (flags)
    );

    cmp_req_route i_route (
        .flags_i   (flags),
        .en_i      (en),
        .dma_sel_i (dma_sel_i),
        .irq_o     (irq_o),
        .dma_req_o (dma_req_o)
    );

    assign rise_flag_o = flags.rise;
    assign fall_flag_o = flags.fall;

    AST_RISE_REQUESTS: assert property (@(posedge clk) disable iff (rst)
        (rise_en_i && rise_flag_o) |-> (irq_o || dma_req_o)); // R7
    AST_FALL_REQUESTS: assert property (@(posedge clk) disable iff (rst)
        (fall_en_i && fall_flag_o) |-> (irq_o || dma_req_o)); // R7
    AST_DMA_MUTES_IRQ: assert property (@(posedge clk) disable iff (rst)
        dma_sel_i |-> !irq_o); // R9
    AST_CPU_MUTES_DMA: assert property (@(posedge clk) disable iff (rst)
        !dma_sel_i |-> !dma_req_o); // R8
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (dma_sel_i && dma_ack_i && $stable(cout_i)) |=> (!rise_flag_o && !fall_flag_o)); // R10

endmodule

// File: tb/test_cmp_edge_req.sv
module test_cmp_edge_req;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cout_i = 1'b0, rise_en_i = 1'b0, fall_en_i = 1'b0, dma_sel_i = 1'b0;
    logic clr_rise_i = 1'b0, clr_fall_i = 1'b0, dma_ack_i = 1'b0;
    logic rise_flag_o, fall_flag_o, irq_o, dma_req_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    cmp_edge_req i_cmp_edge_req (
        .clk(clk), .rst(rst), .cout_i(cout_i), .rise_en_i(rise_en_i),
        .fall_en_i(fall_en_i), .dma_sel_i(dma_sel_i), .clr_rise_i(clr_rise_i),
        .clr_fall_i(clr_fall_i), .dma_ack_i(dma_ack_i), .rise_flag_o(rise_flag_o),
        .fall_flag_o(fall_flag_o), .irq_o(irq_o), .dma_req_o(dma_req_o)
    );

    // Reference model built from the requirements.
    logic m_prev = 1'b0, m_armed = 1'b0, m_rise = 1'b0, m_fall = 1'b0;

    function automatic logic exp_req();
        return (m_rise & rise_en_i) | (m_fall & fall_en_i);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_prev <= 1'b0; m_armed <= 1'b0; m_rise <= 1'b0; m_fall <= 1'b0;
        end else begin
            m_prev  <= cout_i;
            m_armed <= 1'b1;
            m_rise  <= (m_armed & cout_i & ~m_prev) |
                       (m_rise & ~(clr_rise_i | (dma_ack_i & dma_sel_i)));
            m_fall  <= (m_armed & ~cout_i & m_prev) |
                       (m_fall & ~(clr_fall_i | (dma_ack_i & dma_sel_i)));
        end
    end

    task automatic check(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_model();
        check(rise_flag_o, m_rise, "R2", "rise_flag");
        check(fall_flag_o, m_fall, "R3", "fall_flag");
        check(irq_o, exp_req() & ~dma_sel_i, "R8", "irq");
        check(dma_req_o, exp_req() & dma_sel_i, "R9", "dma_req");
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        void'($urandom(32'h5EED_C0DE));
        // Reset with the output held high.
        cout_i = 1'b1; rise_en_i = 1'b1; fall_en_i = 1'b1;
        repeat (3) step();
        check(rise_flag_o, 1'b0, "R1", "rise in reset");
        check(fall_flag_o, 1'b0, "R1", "fall in reset");
        check(irq_o, 1'b0, "R1", "irq in reset");
        check(dma_req_o, 1'b0, "R1", "dma in reset");
        rst = 1'b0;
        step();
        check(rise_flag_o, 1'b0, "R4", "no rise on first edge");
        check(irq_o, 1'b0, "R1", "irq after reset");
        step();
        check(rise_flag_o, 1'b0, "R4", "steady high is no edge");
        // Falling edge.
        cout_i = 1'b0; step();
        check(fall_flag_o, 1'b1, "R3", "fall set");
        check(irq_o, 1'b1, "R8", "irq from fall");
        repeat (3) step();
        check(fall_flag_o, 1'b1, "R5", "fall sticky");
        // Rising edge, with both enables off: the flag is still recorded.
        rise_en_i = 1'b0; fall_en_i = 1'b0;
        cout_i = 1'b1; step();
        check(rise_flag_o, 1'b1, "R2", "rise set");
        check(irq_o, 1'b0, "R7", "no request when disabled");
        rise_en_i = 1'b1; fall_en_i = 1'b1; #1;
        check(irq_o, 1'b1, "R7", "request when enabled");
        // Clear the falling flag only: the rising flag keeps the request up.
        clr_fall_i = 1'b1; step(); clr_fall_i = 1'b0;
        check(fall_flag_o, 1'b0, "R6", "fall cleared");
        check(rise_flag_o, 1'b1, "R6", "rise untouched");
        check(irq_o, 1'b1, "R7", "request held by rise");
        clr_rise_i = 1'b1; step(); clr_rise_i = 1'b0;
        check(irq_o, 1'b0, "R7", "request dropped");
        // A falling edge in the same cycle as its clear: the set wins.
        cout_i = 1'b0; clr_fall_i = 1'b1; step(); clr_fall_i = 1'b0;
        check(fall_flag_o, 1'b1, "R6", "set beats clear");
        // DMA routing.
        dma_sel_i = 1'b1; #1;
        check(dma_req_o, 1'b1, "R9", "dma req");
        check(irq_o, 1'b0, "R9", "irq muted");
        // An acknowledge without DMA select is ignored.
        dma_sel_i = 1'b0; dma_ack_i = 1'b1; step(); dma_ack_i = 1'b0;
        check(fall_flag_o, 1'b1, "R10", "ack ignored");
        dma_sel_i = 1'b1; dma_ack_i = 1'b1; step(); dma_ack_i = 1'b0;
        check(fall_flag_o, 1'b0, "R10", "ack clears");
        check(dma_req_o, 1'b0, "R10", "dma req drops");
        // An acknowledge in the same cycle as a rising edge: the rising flag stays set.
        cout_i = 1'b1; dma_ack_i = 1'b1; step(); dma_ack_i = 1'b0;
        check(rise_flag_o, 1'b1, "R10", "edge beats ack");
        // Seeded random phase against the model.
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 3) == 0) cout_i = ~cout_i;
            clr_rise_i = ($urandom_range(0, 7) == 0);
            clr_fall_i = ($urandom_range(0, 7) == 0);
            dma_ack_i  = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 15) == 0) dma_sel_i = ~dma_sel_i;
            if ($urandom_range(0, 15) == 0) rise_en_i = ~rise_en_i;
            if ($urandom_range(0, 15) == 0) fall_en_i = ~fall_en_i;
            step();
            check_model();
        end
        done = 1'b1;
        summary();
    end

endmodule